// File: doc/BRIEF.md
# GPIO Bank with Edge-Triggered Interrupts

This block controls a bank of 32 general-purpose pins from a simple memory-mapped write port and a combinational read port. Software sees the synchronized level of every pin. It drives pin data and the pin direction mask without a read-modify-write: one address sets bits and a second address clears them. Direction is stored as an output-enable mask, where a 1 makes the pin an output.

Each pin passes through a two-stage synchronizer. The block then compares the synchronized level with its value one cycle earlier. A rise and a fall each have their own per-pin enable register. When an enabled transition is seen, the block latches a sticky event flag for that pin. All flags of the bank are read in one access. Software clears a flag by writing 1 to it. While any flag is set, a single interrupt line stays high.

Top module: `gpio_edge_bank`

## Requirements
- R1: After reset, the pin drive outputs, the direction mask, both edge-enable registers and the event flags are all zero, and the interrupt output is low.
- R2: A read at offset 0x00 returns the pin levels after two register stages. A pin change made before clock edge A is not visible after edge A. It is visible after the following edge.
- R3: A write to offset 0x14 sets each drive bit whose data bit is 1. Drive bits whose data bit is 0 keep their value.
- R4: A write to offset 0x18 clears each drive bit whose data bit is 1. Drive bits whose data bit is 0 keep their value.
- R5: Writes to offset 0x1C set direction bits and writes to offset 0x20 clear them, touching only the bits that are 1 in the data. The mask is read back at offset 0x04, where a bit of 1 marks an output.
- R6: The rise-enable register at 0x28 and the fall-enable register at 0x2C are written whole and read back unchanged. A pin may have both enabled.
- R7: A 0-to-1 transition on a pin whose rise enable is 1 sets that pin's flag in the event register at 0x0C, three clock edges after the pin changes. A transition on a pin with no matching enable sets no flag.
- R8: A 1-to-0 transition on a pin whose fall enable is 1 sets that pin's flag with the same timing as R7. A pin with both enables flags on either transition.
- R9: Writing to 0x0C clears the flags whose data bit is 1 and leaves the other flags alone. A flag stays set until it is cleared this way.
- R10: If an enabled transition and a clearing write for the same flag meet at one clock edge, the flag ends up set.
- R11: The interrupt output is high exactly while at least one flag is set. Clearing an enable bit does not clear a flag that is already set.
- R12: Writes to the read-only offsets 0x00 and 0x04 change no state. Reads at offsets that hold no readable register return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_wr | input | 1 | Write strobe, sampled at the clock edge |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data / bit mask |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pin_in | input | 32 | Asynchronous pin levels |
| pin_out | output | 32 | Drive values toward the pads |
| pin_oe | output | 32 | Output-enable per pin, 1 = drive |
| irq | output | 1 | High while any event flag is set |

## Verification
The edge logic is swept across every pin in turn. Each pin is given one rise and one fall under an enable pattern that mixes rise-only, fall-only and both-edge pins. This separates per-pin mix-ups, swapped rise and fall enables, and leakage into neighbouring flags. The set and clear registers are tried with overlapping masks, which catches a clear that disturbs bits it should not touch or a write that replaces the register instead of updating it. Timed cases pin down the synchronizer depth, the set-over-clear race at a single edge, and the rule that a flag outlives its enable.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned BUS_AW = 8;
  localparam int unsigned BUS_DW = 32;

  localparam logic [BUS_AW-1:0] OFS_PIN_LEVEL = 8'h00;
  localparam logic [BUS_AW-1:0] OFS_DIR_VIEW  = 8'h04;
  localparam logic [BUS_AW-1:0] OFS_EVT_FLAG  = 8'h0C;
  localparam logic [BUS_AW-1:0] OFS_DRV_SET   = 8'h14;
  localparam logic [BUS_AW-1:0] OFS_DRV_CLR   = 8'h18;
  localparam logic [BUS_AW-1:0] OFS_DIR_SET   = 8'h1C;
  localparam logic [BUS_AW-1:0] OFS_DIR_CLR   = 8'h20;
  localparam logic [BUS_AW-1:0] OFS_RISE_EN   = 8'h28;
  localparam logic [BUS_AW-1:0] OFS_FALL_EN   = 8'h2C;

  typedef struct packed {
    logic drv_set;
    logic drv_clr;
    logic dir_set;
    logic dir_clr;
    logic rise_wr;
    logic fall_wr;
    logic flag_clr;
  } wr_strobe_t;
endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_async,
  output logic [NPINS-1:0] level,
  output logic [NPINS-1:0] rise,
  output logic [NPINS-1:0] fall
);
  logic [NPINS-1:0] meta_q;
  logic [NPINS-1:0] stab_q;
  logic [NPINS-1:0] prev_q;

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    logic meta_d, stab_d, prev_d;

    always_comb begin
      meta_d = pin_async[g];
      stab_d = meta_q[g];
      prev_d = stab_q[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q[g] <= 1'b0;
        stab_q[g] <= 1'b0;
        prev_q[g] <= 1'b0;
      end else begin
        meta_q[g] <= meta_d;
        stab_q[g] <= stab_d;
        prev_q[g] <= prev_d;
      end
    end

    assign rise[g] =  stab_q[g] & ~prev_q[g];
    assign fall[g] = ~stab_q[g] &  prev_q[g];
  end

  assign level = stab_q;

  // R7 / R8: a detected transition reflects a level change one cycle later
  assert_edge_tracks_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((rise | fall) != '0) |-> ((level ^ $past(level)) == (rise | fall)));
endmodule

// File: rtl/gpio_ctl_regs.sv
module gpio_ctl_regs
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  wr_strobe_t       stb,
  input  logic [NPINS-1:0] wdata,
  output logic [NPINS-1:0] drv_q,
  output logic [NPINS-1:0] dir_q,
  output logic [NPINS-1:0] rise_en_q,
  output logic [NPINS-1:0] fall_en_q
);
  logic [NPINS-1:0] drv_d, dir_d, rise_en_d, fall_en_d;
  logic             drv_ce, dir_ce, rise_ce, fall_ce;

  always_comb begin
    drv_ce    = stb.drv_set | stb.drv_clr;
    dir_ce    = stb.dir_set | stb.dir_clr;
    rise_ce   = stb.rise_wr;
    fall_ce   = stb.fall_wr;
    drv_d     = stb.drv_set ? (drv_q | wdata) : (drv_q & ~wdata);
    dir_d     = stb.dir_set ? (dir_q | wdata) : (dir_q & ~wdata);
    rise_en_d = wdata;
    fall_en_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drv_q     <= '0;
      dir_q     <= '0;
      rise_en_q <= '0;
      fall_en_q <= '0;
    end else begin
      if (drv_ce)  drv_q     <= drv_d;
      if (dir_ce)  dir_q     <= dir_d;
      if (rise_ce) rise_en_q <= rise_en_d;
      if (fall_ce) fall_en_q <= fall_en_d;
    end
  end

  assert_drv_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    stb.drv_set |=> (((drv_q & $past(wdata)) == $past(wdata)) &&
                     ((drv_q & ~$past(wdata)) == ($past(drv_q) & ~$past(wdata)))));

  assert_drv_clr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    stb.drv_clr |=> (((drv_q & $past(wdata)) == '0) &&
                     ((drv_q & ~$past(wdata)) == ($past(drv_q) & ~$past(wdata)))));

  assert_dir_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(stb.dir_set || stb.dir_clr) |=> $stable(dir_q));

  assert_enables_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(stb.rise_wr || stb.fall_wr) |=> ($stable(rise_en_q) && $stable(fall_en_q)));

  assert_one_strobe_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(stb));
endmodule

// File: rtl/gpio_irq_flags.sv
module gpio_irq_flags #(
  parameter int unsigned NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] rise,
  input  logic [NPINS-1:0] fall,
  input  logic [NPINS-1:0] rise_en,
  input  logic [NPINS-1:0] fall_en,
  input  logic             clr_stb,
  input  logic [NPINS-1:0] wdata,
  output logic [NPINS-1:0] flag_q,
  output logic             irq
);
  logic [NPINS-1:0] set_ev;
  logic [NPINS-1:0] clr_mask;
  logic [NPINS-1:0] flag_d;
  logic             flag_ce;

  always_comb begin
    set_ev   = (rise & rise_en) | (fall & fall_en);
    clr_mask = clr_stb ? wdata : '0;
    flag_ce  = clr_stb | (set_ev != '0);
    flag_d   = (flag_q & ~clr_mask) | set_ev;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= '0;
    else if (flag_ce) flag_q <= flag_d;
  end

  assign irq = |flag_q;

  assert_flag_set_on_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (set_ev != '0) |=> ((flag_q & $past(set_ev)) == $past(set_ev)));

  assert_no_spurious_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag_q & ~$past(flag_q)) & ~$past(set_ev)) == '0);

  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((~flag_q & $past(flag_q)) & ~$past(clr_mask)) == '0);

  assert_set_beats_clr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_stb && ((set_ev & wdata) != '0)) |=>
      ((flag_q & $past(set_ev & wdata)) == $past(set_ev & wdata)));

  assert_irq_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(set_ev) != '0));
endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NPINS = BUS_DW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [BUS_DW-1:0] bus_wdata,
  output logic [BUS_DW-1:0] bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic              irq
);
  logic             rst_sync_n;
  wr_strobe_t       stb;
  logic [NPINS-1:0] wmask;
  logic [NPINS-1:0] level, rise, fall;
  logic [NPINS-1:0] rise_en, fall_en, flags;

  assign wmask = bus_wdata[NPINS-1:0];

  gpio_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_comb begin
    stb = '0;
    if (bus_wr) begin
      case (bus_addr)
        OFS_DRV_SET:  stb.drv_set  = 1'b1;
        OFS_DRV_CLR:  stb.drv_clr  = 1'b1;
        OFS_DIR_SET:  stb.dir_set  = 1'b1;
        OFS_DIR_CLR:  stb.dir_clr  = 1'b1;
        OFS_RISE_EN:  stb.rise_wr  = 1'b1;
        OFS_FALL_EN:  stb.fall_wr  = 1'b1;
        OFS_EVT_FLAG: stb.flag_clr = 1'b1;
        default:      stb = '0;
      endcase
    end
  end

  gpio_in_sync #(.NPINS(NPINS)) u_sync (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .pin_async (pin_in),
    .level     (level),
    .rise      (rise),
    .fall      (fall)
  );

  gpio_ctl_regs #(.NPINS(NPINS)) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .stb       (stb),
    .wdata     (wmask),
    .drv_q     (pin_out),
    .dir_q     (pin_oe),
    .rise_en_q (rise_en),
    .fall_en_q (fall_en)
  );

  gpio_irq_flags #(.NPINS(NPINS)) u_flags (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .rise    (rise),
    .fall    (fall),
    .rise_en (rise_en),
    .fall_en (fall_en),
    .clr_stb (stb.flag_clr),
    .wdata   (wmask),
    .flag_q  (flags),
    .irq     (irq)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_PIN_LEVEL: bus_rdata[NPINS-1:0] = level;
      OFS_DIR_VIEW:  bus_rdata[NPINS-1:0] = pin_oe;
      OFS_EVT_FLAG:  bus_rdata[NPINS-1:0] = flags;
      OFS_RISE_EN:   bus_rdata[NPINS-1:0] = rise_en;
      OFS_FALL_EN:   bus_rdata[NPINS-1:0] = fall_en;
      default:       bus_rdata = '0;
    endcase
  end

  assert_ro_write_R12: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_wr && (bus_addr == OFS_PIN_LEVEL || bus_addr == OFS_DIR_VIEW)) |=>
      ($stable(pin_out) && $stable(pin_oe)));

  assert_enable_clear_keeps_flag_R11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_wr && (bus_addr == OFS_RISE_EN || bus_addr == OFS_FALL_EN)) |=>
      ((flags & $past(flags)) == $past(flags)));
endmodule

// File: tb/sim_gpio_edge_bank.sv
module sim_gpio_edge_bank;
  localparam time CLK_PERIOD = 10ns;

  logic        clk;
  logic        rst_n;
  logic        bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in;
  logic [31:0] pin_out;
  logic [31:0] pin_oe;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;

  gpio_edge_bank u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_in    (pin_in),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .irq       (irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic drive_pins(input logic [31:0] v);
    @(negedge clk);
    pin_in = v;
    repeat (3) @(posedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] rd, exp_out, exp_oe, ren, fen;
    bus_wr = 0; bus_addr = 0; bus_wdata = 0; pin_in = 0; rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    repeat (3) @(posedge clk);

    // R1: reset state
    @(negedge clk);
    chk("R1 pin_out", pin_out, 0);
    chk("R1 pin_oe", pin_oe, 0);
    chk("R1 irq", {31'd0, irq}, 0);
    bus_read(8'h0C, rd); chk("R1 flags", rd, 0);
    bus_read(8'h28, rd); chk("R1 rise_en", rd, 0);
    bus_read(8'h2C, rd); chk("R1 fall_en", rd, 0);

    // R2: two-stage sync latency
    bus_addr = 8'h00;
    @(negedge clk); pin_in = 32'hA5C3_0F81;
    @(posedge clk); @(negedge clk); #1;
    chk("R2 after one edge", bus_rdata, 0);
    @(posedge clk); @(negedge clk); #1;
    chk("R2 after two edges", bus_rdata, 32'hA5C3_0F81);
    drive_pins(32'h0);
    bus_read(8'h00, rd); chk("R2 back to zero", rd, 0);

    // R3 / R4: drive set and clear with overlapping masks
    exp_out = 0;
    for (int k = 0; k < 6; k++) begin
      logic [31:0] m;
      m = (32'h1357_9BDF * (k + 1)) ^ (32'hF0F0_0F0F >> k);
      if (k % 2 == 0) begin
        bus_write(8'h14, m); exp_out = exp_out | m;
        chk("R3 drive set", pin_out, exp_out);
      end else begin
        bus_write(8'h18, m); exp_out = exp_out & ~m;
        chk("R4 drive clear", pin_out, exp_out);
      end
    end

    // R5: direction set/clear and readback
    exp_oe = 0;
    bus_write(8'h1C, 32'hFFFF_0000); exp_oe |= 32'hFFFF_0000;
    bus_read(8'h04, rd); chk("R5 dir set", rd, exp_oe);
    bus_write(8'h20, 32'h00FF_FF00); exp_oe &= ~32'h00FF_FF00;
    bus_read(8'h04, rd); chk("R5 dir clear", rd, exp_oe);
    chk("R5 pin_oe port", pin_oe, exp_oe);

    // R12: read-only writes and unmapped reads
    bus_write(8'h00, 32'hFFFF_FFFF);
    bus_write(8'h04, 32'hFFFF_FFFF);
    chk("R12 ro oe", pin_oe, exp_oe);
    chk("R12 ro out", pin_out, exp_out);
    bus_read(8'h08, rd); chk("R12 unmapped 08", rd, 0);
    bus_read(8'h14, rd); chk("R12 unmapped 14", rd, 0);

    // R6: enable registers, mixed rise / fall / both
    ren = 32'h5555_5555 | 32'h0000_FF00;
    fen = 32'hAAAA_AAAA | 32'h0000_FF00;
    bus_write(8'h28, ren);
    bus_write(8'h2C, fen);
    bus_read(8'h28, rd); chk("R6 rise_en", rd, ren);
    bus_read(8'h2C, rd); chk("R6 fall_en", rd, fen);

    // R7 / R8 / R9 / R11: per-pin sweep
    for (int i = 0; i < 32; i++) begin
      logic [31:0] b;
      b = 32'h1 << i;
      drive_pins(b);
      bus_read(8'h0C, rd); chk("R7 rise flag", rd, ren & b);
      chk("R11 irq rise", {31'd0, irq}, {31'd0, (ren & b) != 0});
      bus_write(8'h0C, 32'hFFFF_FFFF);
      bus_read(8'h0C, rd); chk("R9 cleared", rd, 0);
      drive_pins(32'h0);
      bus_read(8'h0C, rd); chk("R8 fall flag", rd, fen & b);
      bus_write(8'h0C, 32'hFFFF_FFFF);
    end

    // R9: partial clear leaves other flags
    drive_pins(32'h0000_0300);
    bus_write(8'h0C, 32'h0000_0100);
    bus_read(8'h0C, rd); chk("R9 partial clear", rd, 32'h0000_0200);

    // R11: clearing enables keeps flag, irq follows flags
    bus_write(8'h28, 0);
    bus_write(8'h2C, 0);
    bus_read(8'h0C, rd); chk("R11 flag kept", rd, 32'h0000_0200);
    chk("R11 irq held", {31'd0, irq}, 1);
    drive_pins(32'h0);
    bus_read(8'h0C, rd); chk("R7 disabled no flag", rd, 32'h0000_0200);
    bus_write(8'h0C, 32'h0000_0200);
    chk("R11 irq low", {31'd0, irq}, 0);

    // R10: set wins when edge and clear meet
    bus_write(8'h28, 32'h0000_0008);
    @(negedge clk); pin_in = 32'h0000_0008;
    @(posedge clk); @(posedge clk);
    bus_write(8'h0C, 32'h0000_0008);
    bus_read(8'h0C, rd); chk("R10 set beats clear", rd, 32'h0000_0008);
    bus_write(8'h0C, 32'h0000_0008);
    bus_read(8'h0C, rd); chk("R10 later clear", rd, 0);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule